// File: doc/BRIEF.md
# Parallel-In Serial-Out Flagged FIFO

This block buffers 16-bit words arriving on a parallel write port and drains them one bit at a time on a single serial output. One system clock drives everything. A one-cycle write strobe stores a word. A one-cycle shift strobe moves exactly one bit onto the serial pin. An order input chooses, for each word, whether the least or the most significant bit leaves first.

Four active-low status flags follow the occupancy:
- empty
- full
- more than half full
- near an edge, meaning within one eighth of empty or of full

Occupancy counts every word written and not yet fully shifted out. The word currently being serialised is included in that count until its last bit leaves. Writing and shifting are independent, and both may happen in the same cycle.

Top module: `piso_fifo`

## Requirements
- R1: While rst_ni is low, and after it rises with no strobes, the block shows the empty state: empty_no=0, near_edge_no=0, full_no=1, half_no=1, sdata_o=0, and both pointers at slot zero.
- R2: A write strobe stores wdata_i when full_no is high. A write strobe while full_no is low stores nothing, and the word never appears on the output.
- R3: A shift strobe while empty_no is low has no effect: sdata_o keeps its last value and the flags do not move.
- R4: On each shift strobe with data available, the next bit of the current word appears on sdata_o after that clock edge. msb_first_i=0 sends bit 0 first and bit 15 last; msb_first_i=1 sends bit 15 first and bit 0 last.
- R5: msb_first_i is sampled only on the strobe that sends a word's first bit. Changing it in the middle of a word does not change that word's bit order.
- R6: half_no is low exactly when occupancy exceeds DEPTH/2, and high from 0 up to DEPTH/2.
- R7: near_edge_no is low when occupancy is 0 to DEPTH/8-1 or 7*DEPTH/8+1 to DEPTH, and high from DEPTH/8 to 7*DEPTH/8.
- R8: full_no is low only when occupancy equals DEPTH. empty_no is low only when occupancy is zero.
- R9: A word's slot is released, and occupancy decremented, on the strobe that sends its 16th bit. The following strobe sends the first bit of the next word.
- R10: A write and the final-bit shift in the same cycle both take effect and leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per word |
| wdata_i | input | 16 | Parallel write data |
| shift_i | input | 1 | Serial shift strobe, one cycle per bit |
| msb_first_i | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| sdata_o | output | 1 | Serial data, holds last bit when idle |
| empty_no | output | 1 | Low when no word is held |
| full_no | output | 1 | Low when DEPTH words are held |
| half_no | output | 1 | Low when more than DEPTH/2 words are held |
| near_edge_no | output | 1 | Low within one eighth of empty or full |

## Verification
The bench builds the block with DEPTH=16 and the default 16-bit word. At that depth the eighth and half thresholds fall at 2, 8 and 14. This lets a short run step through every occupancy from empty to full and check all four flags at each level, including every threshold crossing. It also makes an ignored write at full, a drain back to empty, and shifts at empty cheap to reach. The tests for a mid-word order change and for a write coinciding with a final bit use the same short depth.

// File: rtl/piso_fifo_pkg.sv
package piso_fifo_pkg;
  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/piso_fifo_mem.sv
module piso_fifo_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // head word stays in place until its last bit leaves
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/piso_fifo_ctrl.sv
module piso_fifo_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rel_i,
  output logic          we_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          avail_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_no,
  output logic          near_edge_no
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LO_C   = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HI_C   = CW'(DEPTH - DEPTH / 8);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  assign we_o    = wr_i && (count_q != FULL_C);
  assign avail_o = (count_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (we_o)  wr_ptr_q <= wr_ptr_q + AW'(1);
      if (rel_i) rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({we_o, rel_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr_o     = wr_ptr_q;
  assign rd_ptr_o     = rd_ptr_q;
  assign empty_no     = (count_q != '0);
  assign full_no      = (count_q != FULL_C);
  assign half_no      = !(count_q > HALF_C);
  assign near_edge_no = (count_q >= LO_C) && (count_q <= HI_C);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_C); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_no) |=> $stable(wr_ptr_q)); // R2
  AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && rel_i) |=> $stable(count_q)); // R10
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !we_o) |=> (count_q == $past(count_q) - CW'(1))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> avail_o); // R3
endmodule

// File: rtl/piso_fifo_ser.sv
module piso_fifo_ser
  import piso_fifo_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             avail_i,
  input  logic             msb_first_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             rel_o,
  output logic             sdata_o
);
  localparam logic [BW-1:0] LAST_C = BW'(WIDTH - 1);

  logic [BW-1:0] bit_cnt_q;
  bit_order_e    order_q, order_eff;
  logic [BW-1:0] idx;
  logic          step;

  assign step      = shift_i && avail_i;
  // order latched on the first bit of each word
  assign order_eff = (bit_cnt_q == '0) ? bit_order_e'(msb_first_i) : order_q;
  assign idx       = (order_eff == ORDER_MSB) ? (LAST_C - bit_cnt_q) : bit_cnt_q;
  assign rel_o     = step && (bit_cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      order_q   <= ORDER_LSB;
      sdata_o   <= 1'b0;
    end else if (step) begin
      sdata_o   <= word_i[idx];
      order_q   <= order_eff;
      bit_cnt_q <= rel_o ? '0 : bit_cnt_q + BW'(1);
    end
  end

  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !avail_i) |=> $stable(sdata_o)); // R3
  AST_ORDER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && bit_cnt_q != '0) |=> $stable(order_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> ($stable(sdata_o) && $stable(bit_cnt_q))); // R4
endmodule

// File: rtl/piso_fifo.sv
module piso_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             shift_i,
  input  logic             msb_first_i,
  output logic             sdata_o,
  output logic             empty_no,
  output logic             full_no,
  output logic             half_no,
  output logic             near_edge_no
);
  logic             we, rel, avail;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [WIDTH-1:0] head;

  piso_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rel_i(rel), .we_o(we),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .avail_o(avail),
    .empty_no, .full_no, .half_no, .near_edge_no
  );

  piso_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i, .we_i(we), .waddr_i(wr_ptr), .wdata_i,
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  piso_fifo_ser #(.WIDTH(WIDTH)) u_ser (
    .clk_i, .rst_ni, .shift_i, .avail_i(avail), .msb_first_i,
    .word_i(head), .rel_o(rel), .sdata_o
  );

  AST_RESET_FLAGS: assert property (@(posedge clk_i)
    !rst_ni |-> (!empty_no && full_no && half_no && !near_edge_no)); // R1
endmodule

// File: tb/piso_fifo_tb.sv
module piso_fifo_tb;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, sh = 1'b0, dir = 1'b0;
  logic [15:0] wd = '0;
  logic        so, e_n, f_n, h_n, a_n;
  int          n_run = 0, n_fail = 0;
  int          occ = 0;
  bit          done = 1'b0;

  // {order, word}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'h0001}, {1'b1, 16'h0001}, {1'b0, 16'h8000},
    {1'b1, 16'hA5C3}, {1'b0, 16'h3C5A}, {1'b1, 16'hFFFE}
  };

  always #10 clk = ~clk;

  piso_fifo #(.DEPTH(D), .WIDTH(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wd), .shift_i(sh),
    .msb_first_i(dir), .sdata_o(so), .empty_no(e_n), .full_no(f_n),
    .half_no(h_n), .near_edge_no(a_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic [15:0] d, input logic s, input logic o);
    @(negedge clk);
    wr = w; wd = d; sh = s; dir = o;
    @(posedge clk);
    #1;
    wr = 1'b0; sh = 1'b0;
  endtask

  task automatic chk_flags(input string ctx);
    chk({ctx, " R8 empty"}, 32'(e_n), 32'(occ != 0));
    chk({ctx, " R8 full"},  32'(f_n), 32'(occ != D));
    chk({ctx, " R6 half"},  32'(h_n), 32'(!(occ > D / 2)));
    chk({ctx, " R7 edge"},  32'(a_n), 32'((occ >= D / 8) && (occ <= D - D / 8)));
  endtask

  task automatic put(input logic [15:0] d);
    tick(1'b1, d, 1'b0, dir);
    if (occ < D) occ++;
  endtask

  task automatic pull(input logic o, output logic [15:0] w);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      tick(1'b0, '0, 1'b1, o);
      if (o) w[15 - i] = so; else w[i] = so;
      if (i == 14) chk("R9 held before last bit", 32'(e_n), 32'(occ != 0));
    end
    occ--;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    #35;
    chk("R1 empty in reset", 32'(e_n), 32'(0));
    chk("R1 full in reset", 32'(f_n), 32'(1));
    chk("R1 half in reset", 32'(h_n), 32'(1));
    chk("R1 edge in reset", 32'(a_n), 32'(0));
    chk("R1 sdata in reset", 32'(so), 32'(0));
    @(negedge clk); rst_n = 1'b1;
    tick(1'b0, '0, 1'b0, 1'b0);
    chk_flags("R1 after reset");

    // table walk: one word in, sixteen bits out
    for (int v = 0; v < 6; v++) begin
      put(VEC[v][15:0]);
      pull(VEC[v][16], got);
      chk("R4 word order", 32'(got), 32'(VEC[v][15:0]));
      chk_flags("R9 drained");
    end

    // fill to full, flags at every level
    for (int k = 0; k < D; k++) begin
      put(16'hA000 + 16'(k));
      chk_flags("fill");
    end
    tick(1'b1, 16'hFFFF, 1'b0, 1'b0);
    chk_flags("R2 write at full");
    for (int k = 0; k < D; k++) begin
      pull(1'b0, got);
      chk("R2 drain data", 32'(got), 32'(16'hA000 + 16'(k)));
      chk_flags("drain");
    end
    // last bit was bit 15 of A00F = 1; shifts at empty keep it
    for (int k = 0; k < 3; k++) tick(1'b0, '0, 1'b1, 1'b0);
    chk("R3 sdata held", 32'(so), 32'(1));
    chk_flags("R3 shift at empty");
    put(16'h0000);
    tick(1'b0, '0, 1'b1, 1'b0);
    chk("R2 overflow word absent", 32'(so), 32'(0));
    for (int k = 0; k < 15; k++) tick(1'b0, '0, 1'b1, 1'b0);
    occ--;
    chk_flags("R9 release");

    // order changed mid-word
    put(16'h0001);
    got = '0;
    tick(1'b0, '0, 1'b1, 1'b0);
    got[0] = so;
    for (int i = 1; i < 16; i++) begin
      tick(1'b0, '0, 1'b1, 1'b1);
      got[i] = so;
    end
    occ--;
    chk("R5 order latched", 32'(got), 32'(16'h0001));

    // write on the final-bit cycle
    put(16'h1234);
    got = '0;
    for (int i = 0; i < 15; i++) begin
      tick(1'b0, '0, 1'b1, 1'b0);
      got[i] = so;
    end
    tick(1'b1, 16'h5678, 1'b1, 1'b0);
    got[15] = so;
    chk("R10 first word", 32'(got), 32'(16'h1234));
    chk_flags("R10 occupancy kept");
    pull(1'b1, got);
    chk("R10 second word", 32'(got), 32'(16'h5678));
    chk_flags("R10 drained");

    // reset while holding data
    put(16'hBEEF); put(16'hCAFE); put(16'h0F0F);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 async reset sdata", 32'(so), 32'(0));
    occ = 0;
    @(negedge clk); rst_n = 1'b1;
    tick(1'b0, '0, 1'b0, 1'b0);
    chk_flags("R1 reset mid-run");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule